// File: doc/BRIEF.md
# SPI Register Port

This block lets an external host read and write a 128-entry, 8-bit register file over a four-wire serial bus. The host lowers an active-low select, clocks in a command byte, then clocks a data byte in or out. The top bit of the command byte picks the direction, and the low seven bits pick the register. A write stores the second byte. A read returns the addressed register on the serial output during that same second byte, so one 16-clock frame completes either access.

All serial inputs are resynchronised into the core clock, and every action happens in that domain. Each completed write is also announced to the core logic by a one-cycle strobe that carries the address and data. The core reads any register through a combinational side port. If the host keeps select low past the second byte, each further byte goes to the next address, and the address wraps from 127 to 0. Input `rdy_i` tells the block whether access is allowed. While it is low, for example during the power-on settling period or while the part is powered down, the block refuses the frame.

The serial clock must be slow enough for edge detection in the core domain: each half period must last at least five core clock cycles.

Top module: `spi_regport`

## Requirements
- R1: After reset every register reads 0 on the core port, no write strobe occurs, and the serial output enable is 0.
- R2: In a frame whose command byte has bit 7 = 1, the completed second byte is stored in the register given by command bits 6..0.
- R3: In a frame whose command byte has bit 7 = 0, the addressed register value appears on SDO, MSB first, during the second byte. Each bit is valid before the rising SCK edge that starts its bit slot and changes only after a falling edge.
- R4: Bus mode 0 is used: SCK idles low, SDI is sampled on the rising edge, and bytes travel MSB first.
- R5: A frame in which select rises before a data byte has received all 8 bits leaves that byte's register unchanged and produces no strobe for it.
- R6: When select stays low after a write data byte, each further complete byte is written to the next address, and address 127 is followed by 0.
- R7: When select stays low after a read data byte, each further byte returns the next register, with the same wrap from 127 to 0.
- R8: While `rdy_i` is low at any point in a frame, that frame writes nothing and does not drive SDO.
- R9: The SDO enable is 0 whenever select is high and 1 during an accepted frame.
- R10: Every completed write data byte produces exactly one single-cycle `wr_stb_o`, with `wr_addr_o` and `wr_data_o` equal to the stored address and value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rdy_i | input | 1 | High when host access is allowed |
| spi_sck_i | input | 1 | Serial clock from the host |
| spi_sdi_i | input | 1 | Serial data from the host |
| spi_csn_i | input | 1 | Active-low frame select |
| spi_sdo_o | output | 1 | Serial data to the host |
| spi_sdo_oe_o | output | 1 | Output enable for SDO (0 means high impedance) |
| wr_stb_o | output | 1 | One-cycle pulse for each committed write |
| wr_addr_o | output | 7 | Address of the committed write |
| wr_data_o | output | 8 | Data of the committed write |
| core_raddr_i | input | 7 | Core-side read address |
| core_rdata_o | output | 8 | Register value at `core_raddr_i` |

## Verification
The embedded assertions check on every cycle that:
- a write strobe always lands its data in the register file;
- strobes never last two cycles;
- no write commits when readiness was low;
- a new frame always starts from the command byte;
- read data is loaded before the next rising serial edge.

The bench scenarios are needed to show the end-to-end behaviour:
- bit ordering on SDO and SDI;
- the address arithmetic of bursts, including the wrap;
- discarding of truncated frames;
- the absence of SDO drive in refused frames.

The bench covers these with a write and read-back sweep of all 128 addresses and a set of short, truncated and wrapping frames.

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int AW   = 7,
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rdy_i,
  input  logic          spi_sck_i,
  input  logic          spi_sdi_i,
  input  logic          spi_csn_i,
  output logic          spi_sdo_o,
  output logic          spi_sdo_oe_o,
  output logic          wr_stb_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  input  logic [AW-1:0] core_raddr_i,
  output logic [DW-1:0] core_rdata_o
);
  localparam int DEPTH = 1 << AW;
  localparam int BCW   = $clog2(DW);
  localparam logic [BCW-1:0] LAST = BCW'(DW - 1);

  logic [SYNC:0]   sck_p;
  logic [SYNC-1:0] sdi_p, csn_p;
  logic            sck_rise, sck_fall, sdi_s, csn_s;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sck_p <= '0;
      sdi_p <= '0;
      csn_p <= '1;
    end else begin
      sck_p <= {sck_p[SYNC-1:0], spi_sck_i};
      sdi_p <= {sdi_p[SYNC-2:0], spi_sdi_i};
      csn_p <= {csn_p[SYNC-2:0], spi_csn_i};
    end

  assign sck_rise = sck_p[SYNC-1] & ~sck_p[SYNC];
  assign sck_fall = ~sck_p[SYNC-1] & sck_p[SYNC];
  assign sdi_s    = sdi_p[SYNC-1];
  assign csn_s    = csn_p[SYNC-1];

  logic [DW-1:0]  regs [DEPTH];
  logic [BCW-1:0] bcnt;
  logic           first_q, wr_q, load_pend, refused_q;
  logic [AW-1:0]  addr_q;
  logic [DW-2:0]  sh_q;
  logic [DW-1:0]  rd_val, tx_q;

  logic [DW-1:0]  in_byte;
  logic           byte_done, wr_nxt, wr_ok;
  logic [AW-1:0]  rd_addr;

  assign in_byte   = {sh_q, sdi_s};
  assign byte_done = sck_rise && (bcnt == LAST);
  assign wr_nxt    = first_q ? in_byte[DW-1] : wr_q;
  assign rd_addr   = first_q ? in_byte[AW-1:0] : addr_q + 1'b1;
  assign wr_ok     = wr_q && !refused_q && rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      bcnt      <= '0;
      first_q   <= 1'b1;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      sh_q      <= '0;
      rd_val    <= '0;
      tx_q      <= '0;
      load_pend <= 1'b0;
      refused_q <= 1'b0;
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      if (csn_s) begin
        bcnt      <= '0;
        first_q   <= 1'b1;
        load_pend <= 1'b0;
        tx_q      <= '0;
        refused_q <= ~rdy_i;
      end else begin
        if (!rdy_i) refused_q <= 1'b1;
        if (sck_rise) begin
          sh_q <= in_byte[DW-2:0];
          bcnt <= bcnt + 1'b1;
        end
        if (byte_done) begin
          if (first_q) begin
            first_q <= 1'b0;
            wr_q    <= in_byte[DW-1];
            addr_q  <= in_byte[AW-1:0];
          end else begin
            addr_q <= addr_q + 1'b1;
            if (wr_ok) begin
              regs[addr_q] <= in_byte;
              wr_stb_o     <= 1'b1;
              wr_addr_o    <= addr_q;
              wr_data_o    <= in_byte;
            end
          end
          if (!wr_nxt) begin
            rd_val    <= regs[rd_addr];
            load_pend <= 1'b1;
          end
        end
        if (sck_fall) begin
          if (load_pend) begin
            tx_q      <= rd_val;
            load_pend <= 1'b0;
          end else begin
            tx_q <= {tx_q[DW-2:0], 1'b0};
          end
        end
      end
    end

  assign spi_sdo_o    = tx_q[DW-1];
  assign spi_sdo_oe_o = ~spi_csn_i & rdy_i & ~refused_q;
  assign core_rdata_o = regs[core_raddr_i];

  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> regs[$past(wr_addr_o)] == $past(wr_data_o));

  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);

  a_r8_ready_at_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> $past(rdy_i));

  a_r5_frame_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(csn_s) |-> (bcnt == '0) && first_q && !load_pend);

  a_r3_data_ready_in_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_rise && !csn_s) |-> !load_pend);
endmodule

// File: tb/spi_regport_tb.sv
module spi_regport_tb_top;
  localparam int CLK_NS = 10;
  localparam int HALF   = 6;

  logic clk = 0, rst_n = 0, rdy = 1, sck = 0, sdi = 0, csn = 1;
  logic sdo, sdo_oe, wr_stb;
  logic [6:0] wr_addr, craddr = '0;
  logic [7:0] wr_data, crdata;
  int nchk = 0, nerr = 0, stb_cnt = 0, cyc = 0;

  always #(CLK_NS/2) clk = ~clk;

  spi_regport dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rdy_i(rdy),
    .spi_sck_i(sck), .spi_sdi_i(sdi), .spi_csn_i(csn),
    .spi_sdo_o(sdo), .spi_sdo_oe_o(sdo_oe),
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .core_raddr_i(craddr), .core_rdata_o(crdata)
  );

  always @(posedge clk) begin
    cyc++;
    if (rst_n && wr_stb) stb_cnt++;
    if (cyc > 190000) begin
      nerr++; nchk++;
      $display("FAIL watchdog act=%0d exp<190000", cyc);
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] tx, input int nbits, output logic [31:0] rx, output logic oe_any);
    rx = '0; oe_any = 0;
    @(negedge clk) csn = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = tx[31-i];
      repeat (HALF) @(negedge clk);
      rx = {rx[30:0], sdo};
      oe_any |= sdo_oe;
      sck = 1;
      repeat (HALF) @(negedge clk);
      sck = 0;
    end
    repeat (HALF) @(negedge clk);
    csn = 1;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic core_rd(input int a, output logic [7:0] v);
    @(negedge clk) craddr = 7'(a);
    #1 v = crdata;
  endtask

  initial begin
    logic [31:0] rx;
    logic oe;
    logic [7:0] v;
    int bad, s0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    bad = 0;
    for (int a = 0; a < 128; a++) begin core_rd(a, v); if (v != 0) bad++; end
    chk(bad == 0, "R1 regs zero", bad, 0);
    chk(sdo_oe == 0, "R1 oe idle", sdo_oe, 0);
    chk(stb_cnt == 0, "R1 no strobe", stb_cnt, 0);
    xfer({8'd77, 24'h0}, 16, rx, oe);
    chk(rx[7:0] == 0, "R1 spi read zero", rx[7:0], 0);
    chk(oe == 1, "R9 oe during read frame", oe, 1);
    chk(sdo_oe == 0, "R9 oe after frame", sdo_oe, 0);

    for (int a = 0; a < 128; a++) begin
      s0 = stb_cnt;
      xfer({1'b1, 7'(a), pat(a), 16'h0}, 16, rx, oe);
      chk(stb_cnt == s0 + 1, "R10 one strobe", stb_cnt, s0 + 1);
      chk(wr_addr == 7'(a) && wr_data == pat(a), "R10 strobe fields", {wr_addr, wr_data}, {7'(a), pat(a)});
      core_rd(a, v);
      chk(v == pat(a), "R2 R4 write stored", v, pat(a));
    end
    for (int a = 0; a < 128; a++) begin
      xfer({1'b0, 7'(a), 24'h0}, 16, rx, oe);
      chk(rx[7:0] == pat(a), "R3 R4 read back", rx[7:0], pat(a));
    end

    s0 = stb_cnt;
    xfer({8'h85, 8'hAA, 16'h0}, 12, rx, oe);
    core_rd(5, v);
    chk(v == pat(5), "R5 12-bit frame discarded", v, pat(5));
    xfer({8'h85, 8'hAA, 16'h0}, 15, rx, oe);
    core_rd(5, v);
    chk(v == pat(5), "R5 15-bit frame discarded", v, pat(5));
    chk(stb_cnt == s0, "R5 no strobe", stb_cnt, s0);

    s0 = stb_cnt;
    xfer({8'h8A, 8'h11, 8'h22, 8'h00}, 20, rx, oe);
    core_rd(10, v);
    chk(v == 8'h11, "R5 R6 first burst byte kept", v, 8'h11);
    core_rd(11, v);
    chk(v == pat(11), "R5 partial burst byte dropped", v, pat(11));
    chk(stb_cnt == s0 + 1, "R10 partial burst strobes", stb_cnt, s0 + 1);

    s0 = stb_cnt;
    xfer({8'h80 | 8'd126, 8'h3C, 8'hC3, 8'h5A}, 32, rx, oe);
    core_rd(126, v); chk(v == 8'h3C, "R6 burst 126", v, 8'h3C);
    core_rd(127, v); chk(v == 8'hC3, "R6 burst 127", v, 8'hC3);
    core_rd(0, v);   chk(v == 8'h5A, "R6 burst wrap 0", v, 8'h5A);
    chk(stb_cnt == s0 + 3, "R10 burst strobes", stb_cnt, s0 + 3);

    xfer({8'd126, 24'h0}, 32, rx, oe);
    chk(rx[23:0] == 24'h3CC35A, "R7 burst read wrap", rx[23:0], 24'h3CC35A);

    s0 = stb_cnt;
    rdy = 0;
    xfer({8'h89, 8'h77, 16'h0}, 16, rx, oe);
    core_rd(9, v);
    chk(v == pat(9), "R8 refused write", v, pat(9));
    chk(oe == 0, "R8 no drive refused", oe, 0);
    chk(stb_cnt == s0, "R8 no strobe", stb_cnt, s0);
    rdy = 1;
    xfer({8'h89, 8'h77, 16'h0}, 16, rx, oe);
    core_rd(9, v);
    chk(v == 8'h77, "R8 accepted after ready", v, 8'h77);
    chk(sdo_oe == 0, "R9 oe idle end", sdo_oe, 0);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule